// File: doc/BRIEF.md
# Processor Context and Service Controller

This block owns the processor's control context: the program-counter designator, the index designator, a packed saved-state byte, the output flag and the interrupt-enable flag. At each instruction boundary it decides whether a direct memory write, a direct memory read or an interrupt is serviced before the next instruction. It also executes the context instructions a decoder hands to it: return, disable, mark, save, wait-for-request, and the small instructions that set the output flag and the two designators.

The block does not hold pointer registers or memory. For every memory cycle it names a pointer register by its 4-bit number. In the same cycle it tells the register file whether to clear, increment or decrement that pointer, and the change takes effect at the end of the cycle. Read data arrives combinationally during the cycle. Each service takes one cycle after acceptance, and the block returns to the boundary state when it is done.

Interrupt entry does not push a return address. It saves the designators as one packed byte, with the index designator in the high nibble and the program-counter designator in the low nibble. It then switches to fixed designators. Return and disable restore both designators from one such byte.

Top module: `ctx_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, X, P, Q and T read 0 and IE reads 1. In that first cycle the block issues register command 1 (clear) to pointer 0.
- R2: A serviced DMA-in request writes dma_data_i to memory through pointer 0 with mem_we_o high. It issues command 2 (increment) to pointer 0 in the same cycle, while dma_in_ack_o is high.
- R3: A serviced DMA-out request reads memory through pointer 0 and increments pointer 0. In the next cycle dma_out_valid_o pulses for one cycle and dma_out_data_o holds the byte read.
- R4: An accepted interrupt loads T with {X,P}, with X in bits 7:4 and P in bits 3:0. It sets X to 2 and P to 1 and clears IE. All of these are visible the cycle after irq_ack_o.
- R5: An interrupt request is never acknowledged while IE is 0, and X and P do not change because of it.
- R6: Requests are taken only in the boundary state, with the priority DMA-in, then DMA-out, then interrupt (only when IE is 1), then a pending command. A command held during service waits.
- R7: Command 0 (wait) enters a state that repeats a read cycle through pointer 0 without changing any pointer. It leaves only when a DMA request or an enabled interrupt is serviced, and then returns to the boundary state.
- R8: Command 1 (return) reads the byte at pointer X, loads X from bits 7:4 and P from bits 3:0, increments pointer X and sets IE to 1.
- R9: Command 2 (disable) does the same as return but clears IE.
- R10: Command 3 (mark) loads T with {X,P}, writes {X,P} through pointer 2, decrements pointer 2 and copies P into X.
- R11: Command 4 (save) writes T through pointer X and changes no pointer.
- R12: Commands 5, 6 and 7 take effect at acceptance. Command 5 sets Q to bit 0 of cmd_nib_i, command 6 sets X to cmd_nib_i, and command 7 sets P to cmd_nib_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_in_req_i | input | 1 | Request to write one byte from the bus into memory |
| dma_out_req_i | input | 1 | Request to read one byte from memory onto the bus |
| irq_req_i | input | 1 | Interrupt request |
| cmd_valid_i | input | 1 | A context command is pending |
| cmd_op_i | input | 3 | Command code (0 wait, 1 return, 2 disable, 3 mark, 4 save, 5 set Q, 6 set X, 7 set P) |
| cmd_nib_i | input | 4 | Operand nibble for commands 5 to 7 |
| dma_data_i | input | 8 | Bus byte for DMA-in |
| mem_rdata_i | input | 8 | Memory read data for the current cycle |
| busy_o | output | 1 | High when not in the boundary state |
| idle_o | output | 1 | High while waiting for a request |
| dma_in_ack_o | output | 1 | DMA-in cycle in progress |
| dma_out_ack_o | output | 1 | DMA-out cycle in progress |
| irq_ack_o | output | 1 | Interrupt entry cycle in progress |
| dma_out_valid_o | output | 1 | One-cycle strobe for dma_out_data_o |
| dma_out_data_o | output | 8 | Byte read by the last DMA-out cycle |
| mem_req_o | output | 1 | Memory cycle this clock |
| mem_we_o | output | 1 | Memory cycle is a write |
| mem_sel_o | output | 4 | Pointer register that addresses the memory cycle |
| mem_wdata_o | output | 8 | Write data |
| rf_cmd_o | output | 2 | Pointer command (0 none, 1 clear, 2 increment, 3 decrement) |
| rf_sel_o | output | 4 | Pointer register the command applies to |
| x_o | output | 4 | Index designator |
| p_o | output | 4 | Program-counter designator |
| t_o | output | 8 | Saved-state byte |
| q_o | output | 1 | Output flag |
| ie_o | output | 1 | Interrupt enable |

## Verification
The hardest case to reach is leaving the wait state while an interrupt is pending with IE at 0. This case needs IE cleared by a real interrupt entry first, then a wait command, then a DMA request that has to wake the block while the interrupt stays ignored. The bench gets there by running the priority scenario first, which leaves IE at 0 after the interrupt is serviced. It then enters the wait state and holds the interrupt line before it raises DMA-out. A sweep over all 256 packed bytes loads each byte with return and then takes an interrupt. This covers every combination of X and P on both the restore and the save path.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  typedef enum logic [3:0] {
    ST_CLR,
    ST_READY,
    ST_IDLE,
    ST_DMAIN,
    ST_DMAOUT,
    ST_IRQ,
    ST_RET,
    ST_DIS,
    ST_MARK,
    ST_SAV
  } ctx_state_e;

  typedef enum logic [1:0] {
    RF_NONE  = 2'd0,
    RF_CLEAR = 2'd1,
    RF_INC   = 2'd2,
    RF_DEC   = 2'd3
  } rf_cmd_e;

  typedef enum logic [2:0] {
    OP_WAIT = 3'd0,
    OP_RET  = 3'd1,
    OP_DIS  = 3'd2,
    OP_MARK = 3'd3,
    OP_SAV  = 3'd4,
    OP_SETQ = 3'd5,
    OP_SETX = 3'd6,
    OP_SETP = 3'd7
  } ctx_op_e;

endpackage

// File: rtl/ctx_arb.sv
module ctx_arb
  import ctx_pkg::*;
(
  input  logic       dma_in_req_i,
  input  logic       dma_out_req_i,
  input  logic       irq_req_i,
  input  logic       ie_i,
  input  logic       in_idle_i,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_op_i,
  output ctx_state_e next_o,
  output logic       cmd_take_o
);
  localparam int NREQ = 3;

  logic [NREQ-1:0] req;
  ctx_state_e      tgt [NREQ];
  ctx_op_e         op;

  // Index 0 has the highest priority.
  assign req    = {irq_req_i & ie_i, dma_out_req_i, dma_in_req_i};
  assign tgt[0] = ST_DMAIN;
  assign tgt[1] = ST_DMAOUT;
  assign tgt[2] = ST_IRQ;
  assign op     = ctx_op_e'(cmd_op_i);

  always_comb begin
    next_o     = in_idle_i ? ST_IDLE : ST_READY;
    cmd_take_o = 1'b0;
    if (|req) begin
      for (int i = NREQ - 1; i >= 0; i--) begin
        if (req[i]) next_o = tgt[i];
      end
    end else if (cmd_valid_i && !in_idle_i) begin
      cmd_take_o = 1'b1;
      case (op)
        OP_WAIT: next_o = ST_IDLE;
        OP_RET:  next_o = ST_RET;
        OP_DIS:  next_o = ST_DIS;
        OP_MARK: next_o = ST_MARK;
        OP_SAV:  next_o = ST_SAV;
        default: next_o = ST_READY;
      endcase
    end
  end
endmodule

// File: rtl/ctx_bus.sv
module ctx_bus
  import ctx_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int DMA_REG  = 0,
  parameter int MARK_REG = 2,
  localparam int BYTE_W  = 2 * NIB_W
) (
  input  ctx_state_e        st_i,
  input  logic [NIB_W-1:0]  x_i,
  input  logic [NIB_W-1:0]  p_i,
  input  logic [BYTE_W-1:0] t_i,
  input  logic [BYTE_W-1:0] dma_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [NIB_W-1:0]  mem_sel_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output rf_cmd_e           rf_cmd_o,
  output logic [NIB_W-1:0]  rf_sel_o
);
  localparam logic [NIB_W-1:0] DMA_SEL  = NIB_W'(DMA_REG);
  localparam logic [NIB_W-1:0] MARK_SEL = NIB_W'(MARK_REG);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_sel_o   = '0;
    mem_wdata_o = '0;
    rf_cmd_o    = RF_NONE;
    rf_sel_o    = '0;
    case (st_i)
      ST_CLR: begin
        rf_cmd_o = RF_CLEAR;
        rf_sel_o = DMA_SEL;
      end
      ST_IDLE: begin
        mem_req_o = 1'b1;
        mem_sel_o = DMA_SEL;
      end
      ST_DMAIN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_sel_o   = DMA_SEL;
        mem_wdata_o = dma_data_i;
        rf_cmd_o    = RF_INC;
        rf_sel_o    = DMA_SEL;
      end
      ST_DMAOUT: begin
        mem_req_o = 1'b1;
        mem_sel_o = DMA_SEL;
        rf_cmd_o  = RF_INC;
        rf_sel_o  = DMA_SEL;
      end
      ST_RET, ST_DIS: begin
        mem_req_o = 1'b1;
        mem_sel_o = x_i;
        rf_cmd_o  = RF_INC;
        rf_sel_o  = x_i;
      end
      ST_MARK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_sel_o   = MARK_SEL;
        mem_wdata_o = {x_i, p_i};
        rf_cmd_o    = RF_DEC;
        rf_sel_o    = MARK_SEL;
      end
      ST_SAV: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_sel_o   = x_i;
        mem_wdata_o = t_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int IRQ_X    = 2,
  parameter int IRQ_P    = 1,
  parameter int DMA_REG  = 0,
  parameter int MARK_REG = 2,
  localparam int BYTE_W  = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_in_req_i,
  input  logic              dma_out_req_i,
  input  logic              irq_req_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [NIB_W-1:0]  cmd_nib_i,
  input  logic [BYTE_W-1:0] dma_data_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              idle_o,
  output logic              dma_in_ack_o,
  output logic              dma_out_ack_o,
  output logic              irq_ack_o,
  output logic              dma_out_valid_o,
  output logic [BYTE_W-1:0] dma_out_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [NIB_W-1:0]  mem_sel_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic [1:0]        rf_cmd_o,
  output logic [NIB_W-1:0]  rf_sel_o,
  output logic [NIB_W-1:0]  x_o,
  output logic [NIB_W-1:0]  p_o,
  output logic [BYTE_W-1:0] t_o,
  output logic              q_o,
  output logic              ie_o
);
  ctx_state_e        st_q, st_nxt;
  logic              cmd_take;
  logic [NIB_W-1:0]  x_q, p_q;
  logic [BYTE_W-1:0] t_q, dout_q;
  logic              q_q, ie_q, dov_q;
  rf_cmd_e           rf_cmd;
  ctx_op_e           op;

  assign op = ctx_op_e'(cmd_op_i);

  ctx_arb u_arb (
    .dma_in_req_i (dma_in_req_i),
    .dma_out_req_i(dma_out_req_i),
    .irq_req_i    (irq_req_i),
    .ie_i         (ie_q),
    .in_idle_i    (st_q == ST_IDLE),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .next_o       (st_nxt),
    .cmd_take_o   (cmd_take)
  );

  ctx_bus #(
    .NIB_W   (NIB_W),
    .DMA_REG (DMA_REG),
    .MARK_REG(MARK_REG)
  ) u_bus (
    .st_i       (st_q),
    .x_i        (x_q),
    .p_i        (p_q),
    .t_i        (t_q),
    .dma_data_i (dma_data_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_sel_o  (mem_sel_o),
    .mem_wdata_o(mem_wdata_o),
    .rf_cmd_o   (rf_cmd),
    .rf_sel_o   (rf_sel_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_CLR;
      x_q    <= '0;
      p_q    <= '0;
      t_q    <= '0;
      q_q    <= 1'b0;
      ie_q   <= 1'b1;
      dov_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      dov_q <= 1'b0;
      case (st_q)
        ST_CLR: st_q <= ST_READY;
        ST_READY, ST_IDLE: begin
          st_q <= st_nxt;
          if (cmd_take) begin
            case (op)
              OP_SETQ: q_q <= cmd_nib_i[0];
              OP_SETX: x_q <= cmd_nib_i;
              OP_SETP: p_q <= cmd_nib_i;
              default: ;
            endcase
          end
        end
        ST_DMAOUT: begin
          dout_q <= mem_rdata_i;
          dov_q  <= 1'b1;
          st_q   <= ST_READY;
        end
        ST_IRQ: begin
          t_q  <= {x_q, p_q};
          x_q  <= NIB_W'(IRQ_X);
          p_q  <= NIB_W'(IRQ_P);
          ie_q <= 1'b0;
          st_q <= ST_READY;
        end
        ST_RET, ST_DIS: begin
          x_q  <= mem_rdata_i[BYTE_W-1:NIB_W];
          p_q  <= mem_rdata_i[NIB_W-1:0];
          ie_q <= (st_q == ST_RET);
          st_q <= ST_READY;
        end
        ST_MARK: begin
          t_q  <= {x_q, p_q};
          x_q  <= p_q;
          st_q <= ST_READY;
        end
        default: st_q <= ST_READY;
      endcase
    end
  end

  assign busy_o          = (st_q != ST_READY);
  assign idle_o          = (st_q == ST_IDLE);
  assign dma_in_ack_o    = (st_q == ST_DMAIN);
  assign dma_out_ack_o   = (st_q == ST_DMAOUT);
  assign irq_ack_o       = (st_q == ST_IRQ);
  assign dma_out_valid_o = dov_q;
  assign dma_out_data_o  = dout_q;
  assign rf_cmd_o        = rf_cmd;
  assign x_o             = x_q;
  assign p_o             = p_q;
  assign t_o             = t_q;
  assign q_o             = q_q;
  assign ie_o            = ie_q;
endmodule

// File: rtl/ctx_ctrl_chk.sv
module ctx_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] dma_data_i,
  input logic [7:0] mem_rdata_i,
  input logic       idle_o,
  input logic       dma_in_ack_o,
  input logic       dma_out_ack_o,
  input logic       irq_ack_o,
  input logic       dma_out_valid_o,
  input logic [7:0] dma_out_data_o,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input logic [3:0] mem_sel_o,
  input logic [7:0] mem_wdata_o,
  input logic [1:0] rf_cmd_o,
  input logic [3:0] rf_sel_o,
  input logic [3:0] x_o,
  input logic [3:0] p_o,
  input logic [7:0] t_o,
  input logic       q_o,
  input logic       ie_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (x_o == 4'd0 && p_o == 4'd0 && t_o == 8'd0 && !q_o && ie_o
                    && rf_cmd_o == 2'd1 && rf_sel_o == 4'd0));

  // R2
  dma_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    dma_in_ack_o |-> (mem_req_o && mem_we_o && mem_sel_o == 4'd0
                      && mem_wdata_o == dma_data_i && rf_cmd_o == 2'd2 && rf_sel_o == 4'd0));

  // R3
  dma_out_data_chk: assert property (@(posedge clk) disable iff (rst)
    dma_out_ack_o |=> (dma_out_valid_o && dma_out_data_o == $past(mem_rdata_i)));

  // R4
  irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack_o |=> (x_o == 4'd2 && p_o == 4'd1 && !ie_o && t_o == $past({x_o, p_o})));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack_o |-> ie_o);

  // R6
  one_service_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dma_in_ack_o, dma_out_ack_o, irq_ack_o, idle_o}));

  // R7
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    idle_o |-> (mem_req_o && !mem_we_o && mem_sel_o == 4'd0 && rf_cmd_o == 2'd0));
endmodule

bind ctx_ctrl ctx_ctrl_chk u_chk (.*);

// File: tb/ctx_ctrl_bench.sv
`timescale 1ns/1ps
module ctx_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dma_in_req = 1'b0, dma_out_req = 1'b0, irq_req = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [3:0] cmd_nib = '0;
  logic [7:0] dma_data = '0;
  logic [7:0] mem_rdata;
  logic       busy, idle, dma_in_ack, dma_out_ack, irq_ack, dout_valid;
  logic [7:0] dout_data, mem_wdata, t;
  logic       mem_req, mem_we, q, ie;
  logic [3:0] mem_sel, rf_sel, x, p;
  logic [1:0] rf_cmd;

  logic [15:0] rf  [16];
  logic [7:0]  mem [256];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ctx_ctrl u_ctx_ctrl (
    .clk(clk), .rst(rst),
    .dma_in_req_i(dma_in_req), .dma_out_req_i(dma_out_req), .irq_req_i(irq_req),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_nib_i(cmd_nib),
    .dma_data_i(dma_data), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .idle_o(idle), .dma_in_ack_o(dma_in_ack), .dma_out_ack_o(dma_out_ack),
    .irq_ack_o(irq_ack), .dma_out_valid_o(dout_valid), .dma_out_data_o(dout_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_sel_o(mem_sel), .mem_wdata_o(mem_wdata),
    .rf_cmd_o(rf_cmd), .rf_sel_o(rf_sel),
    .x_o(x), .p_o(p), .t_o(t), .q_o(q), .ie_o(ie)
  );

  // Register file and memory model
  assign mem_rdata = mem[rf[mem_sel][7:0]];
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[rf[mem_sel][7:0]] <= mem_wdata;
    case (rf_cmd)
      2'd1: rf[rf_sel] <= 16'h0000;
      2'd2: rf[rf_sel] <= rf[rf_sel] + 16'd1;
      2'd3: rf[rf_sel] <= rf[rf_sel] - 16'd1;
      default: ;
    endcase
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [3:0] nib);
    cmd_valid = 1'b1; cmd_op = op; cmd_nib = nib;
    step();
    cmd_valid = 1'b0;
    if (op >= 3'd1 && op <= 3'd4) step();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [7:0] a, exp_b;
    logic [15:0] r5;
    for (int i = 0; i < 16; i++) rf[i] = 16'h1000 | 16'(i * 16);
    rf[0] = 16'h1234;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

    // R1: reset state
    repeat (3) step();
    chk("R1 ie during reset", 32'(ie), 1);
    rst = 1'b0;
    chk("R1 clear cmd", {28'd0, rf_cmd, 2'd0}, {28'd0, 2'd1, 2'd0});
    step();
    chk("R1 ptr0 cleared", 32'(rf[0]), 0);
    chk("R1 context", {20'd0, x, p, t}, 0);
    chk("R1 flags", {30'd0, q, ie}, 1);
    chk("R1 busy", 32'(busy), 0);

    // R12: immediate commands
    run_cmd(3'd5, 4'h1); chk("R12 setq 1", 32'(q), 1);
    run_cmd(3'd5, 4'hE); chk("R12 setq 0", 32'(q), 0);
    run_cmd(3'd6, 4'h7); chk("R12 setx", 32'(x), 7);
    run_cmd(3'd7, 4'h9); chk("R12 setp", 32'(p), 9);

    // R10: mark
    a = rf[2][7:0];
    run_cmd(3'd3, 4'h0);
    chk("R10 t", 32'(t), 32'h79);
    chk("R10 mem", 32'(mem[a]), 32'h79);
    chk("R10 ptr2", 32'(rf[2]), 32'h101F);
    chk("R10 x", {24'd0, x, p}, 32'h99);

    // R11: save
    a = rf[9][7:0];
    run_cmd(3'd4, 4'h0);
    chk("R11 mem", 32'(mem[a]), 32'h79);
    chk("R11 ptr", 32'(rf[9]), 32'h1090);

    // R8 and R4: sweep of every packed byte through return then interrupt entry
    for (int v = 0; v < 256; v++) begin
      rf[5] = 16'h1050;
      mem[8'h50] = 8'(v);
      run_cmd(3'd6, 4'h5);
      run_cmd(3'd1, 4'h0);
      chk("R8 return xp", {24'd0, x, p}, 32'(v));
      chk("R8 return ie", {15'd0, ie, rf[5]}, {15'd0, 1'b1, 16'h1051});
      irq_req = 1'b1;
      step();
      chk("R4 irq ack", 32'(irq_ack), 1);
      irq_req = 1'b0;
      step();
      chk("R4 entry", {15'd0, ie, x, p, t}, {15'd0, 1'b0, 4'h2, 4'h1, 8'(v)});
    end

    // R9: disable (return first to have IE at 1)
    rf[5] = 16'h1050; mem[8'h50] = 8'h56; mem[8'h51] = 8'hC4;
    run_cmd(3'd6, 4'h5);
    run_cmd(3'd1, 4'h0);
    chk("R8 reenable", {23'd0, ie, x, p}, {23'd0, 1'b1, 8'h56});
    run_cmd(3'd2, 4'h0);
    chk("R9 disable", {23'd0, ie, x, p}, {23'd0, 1'b0, 8'hC4});
    chk("R9 ptr", 32'(rf[5]), 32'h1052);

    // R5: interrupt held while IE is 0
    irq_req = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R5 no ack", {22'd0, irq_ack, busy, x, p}, {22'd0, 2'b00, 8'hC4});
    end
    irq_req = 1'b0;

    // R2: DMA in
    for (int k = 0; k < 4; k++) begin
      a = rf[0][7:0];
      dma_data = 8'hA0 + 8'(k * 3);
      dma_in_req = 1'b1;
      step();
      chk("R2 ack", 32'(dma_in_ack), 1);
      dma_in_req = 1'b0;
      step();
      chk("R2 mem", 32'(mem[a]), 32'(8'hA0 + 8'(k * 3)));
      chk("R2 ptr0", 32'(rf[0]), 32'(k + 1));
    end

    // R3: DMA out
    for (int k = 0; k < 3; k++) begin
      a = rf[0][7:0];
      exp_b = mem[a];
      dma_out_req = 1'b1;
      step();
      chk("R3 ack", 32'(dma_out_ack), 1);
      dma_out_req = 1'b0;
      step();
      chk("R3 data", {23'd0, dout_valid, dout_data}, {23'd0, 1'b1, exp_b});
      chk("R3 ptr0", 32'(rf[0]), 32'(k + 5));
      step();
      chk("R3 strobe ends", 32'(dout_valid), 0);
    end

    // R6: all requests plus a command at once
    rf[5] = 16'h1050; mem[8'h50] = 8'h56;
    run_cmd(3'd6, 4'h5);
    run_cmd(3'd1, 4'h0);
    dma_in_req = 1'b1; dma_out_req = 1'b1; irq_req = 1'b1;
    cmd_valid = 1'b1; cmd_op = 3'd5; cmd_nib = 4'h1;
    step();
    chk("R6 dma in first", {29'd0, dma_in_ack, dma_out_ack, irq_ack}, 3'b100);
    dma_in_req = 1'b0;
    step(); step();
    chk("R6 dma out second", {29'd0, dma_in_ack, dma_out_ack, irq_ack}, 3'b010);
    dma_out_req = 1'b0;
    step(); step();
    chk("R6 irq third", {29'd0, dma_in_ack, dma_out_ack, irq_ack}, 3'b001);
    irq_req = 1'b0;
    step();
    chk("R6 command waited", 32'(q), 0);
    step();
    cmd_valid = 1'b0;
    chk("R6 command last", 32'(q), 1);

    // R7: wait state, woken by DMA-out while interrupt pending with IE 0
    r5 = rf[0];
    run_cmd(3'd0, 4'h0);
    for (int k = 0; k < 3; k++) begin
      chk("R7 idle bus", {26'd0, idle, mem_req, mem_we, rf_cmd, 1'b0},
          {26'd0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0});
      chk("R7 sel", 32'(mem_sel), 0);
      step();
    end
    irq_req = 1'b1;
    step(); step();
    chk("R7 irq no wake", {30'd0, idle, irq_ack}, 2'b10);
    chk("R7 ptr0 kept", 32'(rf[0]), 32'(r5));
    exp_b = mem[rf[0][7:0]];
    dma_out_req = 1'b1;
    step();
    chk("R7 wake by dma", {30'd0, idle, dma_out_ack}, 2'b01);
    dma_out_req = 1'b0;
    step();
    chk("R7 resume", {29'd0, busy, idle, dout_valid}, 3'b001);
    chk("R7 data", 32'(dout_data), 32'(exp_b));
    irq_req = 1'b0;
    step();
    chk("R7 stays ready", 32'(busy), 0);

    done = 1;
    finish_run();
  end
endmodule